// File: doc/BRIEF.md
# Host Write Port with FIFO-Select Steering

This block receives writes from an asynchronous host parallel bus and turns each completed write into one single-cycle pulse in a local clock domain. A write is active while both the chip-select and the write strobe are low. The block passes that combined strobe through a two-flop synchronizer. Address, steering line and data travel through the same stages, so they are taken as they stood in the last sampled active cycle. When the strobe goes inactive, the write is finished and is routed to one of two destinations.

When the steering line (`fifo_sel`) is high during the write, the word goes to a transmit-FIFO push port and no address bit is decoded. This lets a host that must keep incrementing its address stream data into the FIFO. When the steering line is low, address bits A[2:1] pick one of four 32-bit register slots on a register-write port. In the half-width bus mode, the upper data lanes are ignored. Two successive FIFO writes are then packed into one 32-bit word before the push. A push that meets a full FIFO is dropped and raises a sticky overflow flag.

Top module: `hostwr_port`

## Requirements
- R1: After reset, `fifo_push`, `reg_we` and `ovf_flag` are low, and `fifo_wdata`, `reg_sel` and `reg_wdata` are zero.
- R2: A write happens when `cs_n` and `wr_n` are both low. Each write produces exactly one single-cycle pulse on `fifo_push` or `reg_we`. This holds when the active and inactive phases are each only two local clock periods long, with writes back to back. Holding `cs_n` low while `wr_n` stays high produces no pulse.
- R3: With `fifo_sel` high in the write, the write goes to the FIFO whatever the address is, and `reg_we` stays low.
- R4: With `fifo_sel` low, `reg_we` pulses with `reg_sel` equal to `addr[1:0]` (bus lines A[2:1]). `addr[6:2]` (A[7:3]) have no effect, and no push occurs.
- R5: With `half_mode` high, `data[31:16]` is ignored. A register write carries `data[15:0]` with the upper 16 bits zero.
- R6: With `half_mode` high, the first FIFO write of a pair gives no push. The second write pushes one word, with the first write's `data[15:0]` in bits 15:0 and the second write's in bits 31:16.
- R7: A full-width FIFO write pushes its full 32-bit word and discards any half-word left waiting by an unpaired half-width write. The next half-width pair then starts afresh.
- R8: If `fifo_full` is high when a push is due, the word is dropped and `ovf_flag` goes high. The flag stays high until a cycle with `ovf_clr` high, and a new overflow in that same cycle wins over the clear.
- R9: `fifo_push` is never high in the cycle after one in which `fifo_full` was high, and `fifo_push` and `reg_we` are never high together.
- R10: Address, `fifo_sel` and data are taken from the write's active phase. Changing them in the same instant the strobes rise does not alter the routed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| addr | input | 7 | Host word address A[7:1]; bit 0 is A[1] |
| fifo_sel | input | 1 | Steers the write to the FIFO, timed like an address line |
| data | input | 32 | Host write data |
| half_mode | input | 1 | 1 = 16-bit host bus, 0 = 32-bit |
| fifo_full | input | 1 | FIFO cannot accept a push |
| ovf_clr | input | 1 | Clears the overflow flag |
| fifo_push | output | 1 | Single-cycle FIFO push pulse |
| fifo_wdata | output | 32 | Word pushed with `fifo_push` |
| reg_we | output | 1 | Single-cycle register-write pulse |
| reg_sel | output | 2 | Register slot for `reg_we` |
| reg_wdata | output | 32 | Data for `reg_we` |
| ovf_flag | output | 1 | Sticky dropped-push flag |

## Verification
Register writes are applied with different upper address bits and differing slot bits. These show that only A[2:1] steer the write, and that a set steering line overrides any address. Half-width pairs, an unpaired half followed by a full-width word, and a strobe with only chip-select low separate packing order, stale-half discard and the strobe qualification. Back-to-back writes at two-cycle phases, with the bus scrambled right at strobe release, show one pulse per write and capture from the active phase. Writes against a full FIFO, followed by a clear, exercise the drop, the stickiness of the flag and its release.

// File: rtl/hostwr_pkg.sv
package hostwr_pkg;
    localparam int DATA_W    = 32;
    localparam int HALF_W    = DATA_W / 2;
    localparam int REG_SEL_W = 2;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_REG  = 2'd1,
        ROUTE_FIFO = 2'd2
    } route_e;

    typedef struct packed {
        logic                 push;
        logic [DATA_W-1:0]    word;
        logic                 we;
        logic [REG_SEL_W-1:0] sel;
        logic [DATA_W-1:0]    wdata;
        logic                 pend;
        logic [HALF_W-1:0]    pend_lo;
        logic                 ovf;
    } route_st_t;
endpackage

// File: rtl/hostwr_sync.sv
module hostwr_sync #(
    parameter int W      = 35,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         act_raw,
    input  logic [W-1:0] bus_raw,
    output logic         done,
    output logic [W-1:0] cap
);
    // Strobe and bus travel through identical stages so they stay aligned.
    logic [STAGES-1:0]        act_d, act_q;
    logic [STAGES-1:0][W-1:0] bus_d, bus_q;
    logic                     last_d, last_q;
    logic [W-1:0]             cap_d, cap_q;

    always_comb begin
        act_d  = {act_q[STAGES-2:0], act_raw};
        bus_d  = {bus_q[STAGES-2:0], bus_raw};
        last_d = act_q[STAGES-1];
        cap_d  = act_q[STAGES-1] ? bus_q[STAGES-1] : cap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= '0;
            bus_q  <= '0;
            last_q <= 1'b0;
            cap_q  <= '0;
        end else begin
            act_q  <= act_d;
            bus_q  <= bus_d;
            last_q <= last_d;
            cap_q  <= cap_d;
        end
    end

    // End of write: synchronized strobe was active and is now inactive.
    assign done = last_q & ~act_q[STAGES-1];
    assign cap  = cap_q;
endmodule

// File: rtl/hostwr_decode.sv
module hostwr_decode
    import hostwr_pkg::*;
(
    input  logic                 done,
    input  logic                 fsel,
    input  logic [REG_SEL_W-1:0] slot,
    input  logic [DATA_W-1:0]    data,
    input  logic                 half_mode,
    output route_e               kind,
    output logic [REG_SEL_W-1:0] sel,
    output logic [DATA_W-1:0]    data_m
);
    always_comb begin
        if (!done)     kind = ROUTE_NONE;
        else if (fsel) kind = ROUTE_FIFO;
        else           kind = ROUTE_REG;
        sel    = slot;
        data_m = half_mode ? {{HALF_W{1'b0}}, data[HALF_W-1:0]} : data;
    end
endmodule

// File: rtl/hostwr_route.sv
module hostwr_route
    import hostwr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  route_e               kind,
    input  logic [REG_SEL_W-1:0] sel,
    input  logic [DATA_W-1:0]    data_m,
    input  logic                 half_mode,
    input  logic                 fifo_full,
    input  logic                 ovf_clr,
    output route_st_t            st
);
    route_st_t st_d, st_q;
    logic      ovf_set;

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        st_d.we   = 1'b0;
        ovf_set   = 1'b0;
        case (kind)
            ROUTE_REG: begin
                st_d.we    = 1'b1;
                st_d.sel   = sel;
                st_d.wdata = data_m;
            end
            ROUTE_FIFO: begin
                if (half_mode && !st_q.pend) begin
                    st_d.pend    = 1'b1;
                    st_d.pend_lo = data_m[HALF_W-1:0];
                end else begin
                    st_d.pend = 1'b0;
                    if (fifo_full) begin
                        ovf_set = 1'b1;
                    end else begin
                        st_d.push = 1'b1;
                        st_d.word = half_mode ? {data_m[HALF_W-1:0], st_q.pend_lo} : data_m;
                    end
                end
            end
            default: ;
        endcase
        st_d.ovf = ovf_set | (st_q.ovf & ~ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/hostwr_port.sv
module hostwr_port
    import hostwr_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 wr_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 fifo_sel,
    input  logic [DATA_W-1:0]    data,
    input  logic                 half_mode,
    input  logic                 fifo_full,
    input  logic                 ovf_clr,
    output logic                 fifo_push,
    output logic [DATA_W-1:0]    fifo_wdata,
    output logic                 reg_we,
    output logic [REG_SEL_W-1:0] reg_sel,
    output logic [DATA_W-1:0]    reg_wdata,
    output logic                 ovf_flag
);
    localparam int BUS_W = 1 + REG_SEL_W + DATA_W;

    logic                 act_raw;
    logic [BUS_W-1:0]     bus_raw, cap;
    logic                 done;
    route_e               kind;
    logic [REG_SEL_W-1:0] sel;
    logic [DATA_W-1:0]    data_m;
    route_st_t            st;
    logic                 unused_addr_hi;

    // Upper address lines take no part in any decode.
    assign unused_addr_hi = ^addr[ADDR_W-1:REG_SEL_W];
    assign act_raw        = ~cs_n & ~wr_n;
    assign bus_raw        = {fifo_sel, addr[REG_SEL_W-1:0], data};

    hostwr_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_raw (act_raw),
        .bus_raw (bus_raw),
        .done    (done),
        .cap     (cap)
    );

    hostwr_decode i_decode (
        .done      (done),
        .fsel      (cap[BUS_W-1]),
        .slot      (cap[DATA_W +: REG_SEL_W]),
        .data      (cap[DATA_W-1:0]),
        .half_mode (half_mode),
        .kind      (kind),
        .sel       (sel),
        .data_m    (data_m)
    );

    hostwr_route i_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .sel       (sel),
        .data_m    (data_m),
        .half_mode (half_mode),
        .fifo_full (fifo_full),
        .ovf_clr   (ovf_clr),
        .st        (st)
    );

    assign fifo_push  = st.push;
    assign fifo_wdata = st.word;
    assign reg_we     = st.we;
    assign reg_sel    = st.sel;
    assign reg_wdata  = st.wdata;
    assign ovf_flag   = st.ovf;
endmodule

// File: rtl/hostwr_chk.sv
module hostwr_chk (
    input logic clk,
    input logic rst_n,
    input logic fifo_full,
    input logic ovf_clr,
    input logic fifo_push,
    input logic reg_we,
    input logic ovf_flag
);
    a_r2_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> !fifo_push);
    a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && reg_we));
    a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !$past(fifo_full));
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
    a_r8_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(fifo_full));
endmodule

bind hostwr_port hostwr_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_full (fifo_full),
    .ovf_clr   (ovf_clr),
    .fifo_push (fifo_push),
    .reg_we    (reg_we),
    .ovf_flag  (ovf_flag)
);

// File: tb/test_hostwr_port.sv
`timescale 1ns/1ps
module test_hostwr_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1;
    logic [6:0]  addr = '0;
    logic        fifo_sel = 1'b0;
    logic [31:0] data = '0;
    logic        half_mode = 1'b0, fifo_full = 1'b0, ovf_clr = 1'b0;
    logic        fifo_push, reg_we, ovf_flag;
    logic [31:0] fifo_wdata, reg_wdata;
    logic [1:0]  reg_sel;

    int n_chk = 0, n_bad = 0;
    int push_cnt = 0, we_cnt = 0;
    logic [31:0] last_push = '0, last_wdata = '0;
    logic [1:0]  last_sel = '0;

    always #10 clk = ~clk;

    hostwr_port i_hostwr_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .fifo_sel(fifo_sel), .data(data), .half_mode(half_mode),
        .fifo_full(fifo_full), .ovf_clr(ovf_clr), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ovf_flag(ovf_flag)
    );

    always @(negedge clk) begin
        if (rst_n && fifo_push) begin push_cnt++; last_push = fifo_wdata; end
        if (rst_n && reg_we) begin we_cnt++; last_sel = reg_sel; last_wdata = reg_wdata; end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host write; bus scrambled at the instant the strobes rise (R10).
    task automatic host_wr(input logic fs, input logic [6:0] a, input logic [31:0] d,
                           input int act_cyc, input int idle_cyc);
        @(negedge clk);
        fifo_sel = fs; addr = a; data = d; cs_n = 1'b0; wr_n = 1'b0;
        repeat (act_cyc) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        fifo_sel = ~fs; addr = ~a; data = ~d;
        repeat (idle_cyc) @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!fifo_push && !reg_we && !ovf_flag, "R1 pulses/flag", {29'd0, fifo_push, reg_we, ovf_flag}, 0);
        chk(fifo_wdata == 0 && reg_wdata == 0 && reg_sel == 0, "R1 data", fifo_wdata | reg_wdata, 0);
    endtask

    task automatic t_reg_route();
        int p0 = push_cnt, w0 = we_cnt;
        host_wr(1'b0, 7'b1011_010, 32'h1234_5678, 2, 2); settle();
        chk(we_cnt == w0 + 1, "R4 reg_we count", we_cnt, w0 + 1);
        chk(last_sel == 2'd2, "R4 slot from A[2:1]", last_sel, 2);
        chk(last_wdata == 32'h1234_5678, "R10 reg data from active phase", last_wdata, 32'h1234_5678);
        host_wr(1'b0, 7'b0100_111, 32'h9ABC_DEF0, 3, 3); settle();
        chk(last_sel == 2'd3 && last_wdata == 32'h9ABC_DEF0, "R4 upper address ignored", last_wdata, 32'h9ABC_DEF0);
        chk(push_cnt == p0, "R4 no push on register write", push_cnt, p0);
    endtask

    task automatic t_fifo32();
        int p0 = push_cnt, w0 = we_cnt;
        host_wr(1'b1, 7'b0000_001, 32'hA5A5_0F0F, 2, 2); settle();
        host_wr(1'b1, 7'b1111_110, 32'h0102_0304, 2, 2); settle();
        chk(push_cnt == p0 + 2, "R3 push count", push_cnt, p0 + 2);
        chk(last_push == 32'h0102_0304, "R3 word any address", last_push, 32'h0102_0304);
        chk(we_cnt == w0, "R3 no reg write", we_cnt, w0);
    endtask

    task automatic t_cs_only();
        int p0 = push_cnt, w0 = we_cnt;
        @(negedge clk); fifo_sel = 1'b1; cs_n = 1'b0;
        repeat (4) @(negedge clk); cs_n = 1'b1; settle();
        chk(push_cnt == p0 && we_cnt == w0, "R2 chip select alone", push_cnt + we_cnt, p0 + w0);
    endtask

    task automatic t_half_reg();
        half_mode = 1'b1;
        host_wr(1'b0, 7'b0000_001, 32'hABCD_1234, 2, 2); settle();
        chk(last_wdata == 32'h0000_1234 && last_sel == 2'd1, "R5 upper lanes ignored", last_wdata, 32'h0000_1234);
        half_mode = 1'b0;
    endtask

    task automatic t_half_fifo();
        int p0 = push_cnt;
        half_mode = 1'b1;
        host_wr(1'b1, 7'd0, 32'hFFFF_1111, 2, 2); settle();
        chk(push_cnt == p0, "R6 first half no push", push_cnt, p0);
        host_wr(1'b1, 7'd5, 32'hEEEE_2222, 2, 2); settle();
        chk(push_cnt == p0 + 1, "R6 pair push count", push_cnt, p0 + 1);
        chk(last_push == 32'h2222_1111, "R6 low half first", last_push, 32'h2222_1111);
        half_mode = 1'b0;
    endtask

    task automatic t_stale_half();
        int p0 = push_cnt;
        half_mode = 1'b1;
        host_wr(1'b1, 7'd0, 32'h0000_3333, 2, 2); settle();
        half_mode = 1'b0;
        host_wr(1'b1, 7'd0, 32'hCAFE_F00D, 2, 2); settle();
        chk(push_cnt == p0 + 1 && last_push == 32'hCAFE_F00D, "R7 full word pushed", last_push, 32'hCAFE_F00D);
        half_mode = 1'b1;
        host_wr(1'b1, 7'd0, 32'h0000_4444, 2, 2); settle();
        chk(push_cnt == p0 + 1, "R7 stale half discarded", push_cnt, p0 + 1);
        host_wr(1'b1, 7'd0, 32'h0000_5555, 2, 2); settle();
        chk(last_push == 32'h5555_4444, "R7 fresh pair", last_push, 32'h5555_4444);
        half_mode = 1'b0;
    endtask

    task automatic t_full();
        int p0 = push_cnt, w0 = we_cnt;
        fifo_full = 1'b1;
        host_wr(1'b1, 7'd0, 32'h7777_7777, 2, 2); settle();
        chk(push_cnt == p0, "R8 R9 dropped when full", push_cnt, p0);
        chk(ovf_flag == 1'b1, "R8 overflow set", ovf_flag, 1);
        host_wr(1'b0, 7'd0, 32'h0000_0001, 2, 2); settle();
        chk(ovf_flag == 1'b1 && we_cnt == w0 + 1, "R8 flag sticky", ovf_flag, 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        @(negedge clk);
        chk(ovf_flag == 1'b0, "R8 cleared", ovf_flag, 0);
        fifo_full = 1'b0;
    endtask

    task automatic t_fast();
        int p0 = push_cnt;
        for (int i = 0; i < 4; i++) host_wr(1'b1, 7'(i), 32'h1000_0000 + 32'(i), 2, 2);
        settle();
        chk(push_cnt == p0 + 4, "R2 back-to-back minimum phases", push_cnt, p0 + 4);
        chk(last_push == 32'h1000_0003, "R10 last word intact", last_push, 32'h1000_0003);
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reg_route();
        t_fifo32();
        t_cs_only();
        t_half_reg();
        t_half_fifo();
        t_stale_half();
        t_full();
        t_fast();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule